// File: doc/BRIEF.md
# Combining Branch Direction Predictor with Agreement Confidence

This block guesses the direction of conditional branches at fetch. It keeps two direction tables of 2-bit saturating counters. One is indexed by the fetch PC XORed with a global history of recent branch directions. The other is indexed by the PC alone. A third table, also indexed by the PC, selects which of the two gives the prediction. Alongside each prediction the block raises a one-bit confidence flag. The flag needs no table of its own: it is high only when both direction counters sit in a saturated state and point the same way.

The history register moves ahead speculatively. Each valid lookup shifts the predicted direction into it at the next clock edge. The counters change only when a branch commits, through the update port. The update port carries the PC, the resolved direction and the history snapshot that the lookup reported. When a branch turns out mispredicted, the repair port rebuilds the history from that snapshot with the true direction appended. Lookups are combinational. The PC ports carry only the word-index bits [12:2] of the address.

Top module: `combining_predictor`

## Requirements
- R1: After reset every counter in all three tables holds 1 (weak not-taken) and the history is zero, so an untrained lookup predicts not-taken with low confidence and reports history 0.
- R2: The history-based table is indexed by history XOR PC[12:2]. The PC-only table and the selector are indexed by PC[12:2].
- R3: A counter value of 2 or 3 means taken. A selector value of 2 or 3 picks the history-based table, and 0 or 1 picks the PC-only table.
- R4: On a commit update, both direction counters at the update's indices step one toward the resolved direction and saturate at 0 and at 3.
- R5: The selector counter moves only when the two direction counters disagreed at commit. It steps toward the table whose direction matched the outcome.
- R6: Confidence is 1 only when both direction counters are at 0 or 3 and give the same direction, and 0 otherwise, even when both are saturated but opposed.
- R7: A lookup with lk_valid high shifts its predicted direction into bit 0 of the history at the next edge. With lk_valid low the history is unchanged. lk_hist always shows the current history.
- R8: A repair loads the history with {snapshot[9:0], outcome}. When a repair and a valid lookup fall in the same cycle, the repair wins.
- R9: A lookup reads the table state from before any commit update in the same cycle. That update is visible to lookups from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup is real; advance the history speculatively |
| lk_pc | input | 11 | Fetch PC bits [12:2] |
| lk_taken | output | 1 | Predicted direction (1 = taken) |
| lk_confident | output | 1 | High-confidence flag |
| lk_hist | output | 11 | Current history, to be kept as the branch's snapshot |
| up_valid | input | 1 | Commit update strobe |
| up_pc | input | 11 | Committed branch PC bits [12:2] |
| up_taken | input | 1 | Resolved direction |
| up_hist | input | 11 | History snapshot taken at the branch's lookup |
| rp_valid | input | 1 | Misprediction repair strobe |
| rp_hist | input | 11 | History snapshot of the mispredicted branch |
| rp_taken | input | 1 | Resolved direction of the mispredicted branch |

## Verification
A misprediction repair and a valid speculative lookup can land on the history register in the same cycle. The bench drives both in one cycle, choosing a snapshot whose repaired value differs from every value a speculative shift could give. It then checks lk_hist at the next cycle. A commit update and a lookup of the same entry can also coincide. That case is judged by sampling lk_taken before the edge, where the old counter must show, and again after it, where the new one must.

// File: rtl/bpred_pkg.sv
package bpred_pkg;

  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_WEAK_NT = 2'd1;
  localparam int   NUM_TBL     = 3;
  localparam int   TBL_GLB     = 0;
  localparam int   TBL_BIM     = 1;
  localparam int   TBL_SEL     = 2;

  // direction held by a counter: upper half means taken
  function automatic logic ctr_dir(input ctr_t c);
    return c[1];
  endfunction

  // saturated at either end
  function automatic logic ctr_strong(input ctr_t c);
    return (c == 2'd0) || (c == 2'd3);
  endfunction

  // one saturating step up or down
  function automatic ctr_t ctr_bump(input ctr_t c, input logic up);
    ctr_t r;
    if (up) r = (c == 2'd3) ? c : c + 2'd1;
    else    r = (c == 2'd0) ? c : c - 2'd1;
    return r;
  endfunction

endpackage

// File: rtl/pred_ctr_table.sv
module pred_ctr_table
  import bpred_pkg::*;
#(
  parameter int   IDX_BITS = 11,
  parameter ctr_t INIT     = CTR_WEAK_NT
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [IDX_BITS-1:0] rd_idx_a,
  output ctr_t                rd_val_a,
  input  logic [IDX_BITS-1:0] rd_idx_b,
  output ctr_t                rd_val_b,
  input  logic                wr_en,
  input  logic [IDX_BITS-1:0] wr_idx,
  input  ctr_t                wr_val
);

  localparam int DEPTH = 1 << IDX_BITS;

  ctr_t mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= INIT;
    end else if (wr_en) begin
      mem[wr_idx] <= wr_val;
    end
  end

  assign rd_val_a = mem[rd_idx_a];
  assign rd_val_b = mem[rd_idx_b];

  // a written counter may move by at most one step from what it held
  AST_CTR_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (({1'b0, wr_val} == {1'b0, mem[wr_idx]}) ||
               ({1'b0, wr_val} == {1'b0, mem[wr_idx]} + 3'd1) ||
               ({1'b0, mem[wr_idx]} == {1'b0, wr_val} + 3'd1))); // R4

endmodule

// File: rtl/pred_hist_reg.sv
module pred_hist_reg #(
  parameter int HB = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          spec_valid,
  input  logic          spec_taken,
  input  logic          fix_valid,
  input  logic [HB-1:0] fix_snap,
  input  logic          fix_taken,
  output logic [HB-1:0] hist
);

  function automatic logic [HB-1:0] push(input logic [HB-1:0] h, input logic t);
    return (h << 1) | {{(HB-1){1'b0}}, t};
  endfunction

  logic          do_fix;
  logic          do_spec;
  logic [HB-1:0] hist_nxt;

  assign do_fix  = fix_valid;
  assign do_spec = spec_valid && !fix_valid;

  always_comb begin
    hist_nxt = hist;
    if (do_fix)       hist_nxt = push(fix_snap, fix_taken);
    else if (do_spec) hist_nxt = push(hist, spec_taken);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist <= '0;
    else        hist <= hist_nxt;
  end

  AST_HIST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!spec_valid && !fix_valid) |=> $stable(hist)); // R7

  AST_SPEC_SHIFT_IN: assert property (@(posedge clk) disable iff (!rst_n)
    (spec_valid && !fix_valid) |=> (hist[0] == $past(spec_taken)) &&
                                   (hist[HB-1:1] == $past(hist[HB-2:0]))); // R7

  AST_REPAIR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    fix_valid |=> (hist[0] == $past(fix_taken)) &&
                  (hist[HB-1:1] == $past(fix_snap[HB-2:0]))); // R8

endmodule

// File: rtl/combining_predictor.sv
module combining_predictor
  import bpred_pkg::*;
#(
  parameter int IDX_BITS = 11
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                lk_valid,
  input  logic [IDX_BITS+1:2] lk_pc,
  output logic                lk_taken,
  output logic                lk_confident,
  output logic [IDX_BITS-1:0] lk_hist,
  input  logic                up_valid,
  input  logic [IDX_BITS+1:2] up_pc,
  input  logic                up_taken,
  input  logic [IDX_BITS-1:0] up_hist,
  input  logic                rp_valid,
  input  logic [IDX_BITS-1:0] rp_hist,
  input  logic                rp_taken
);

  localparam int IB = IDX_BITS;

  function automatic logic [IB-1:0] glb_index(input logic [IB-1:0] h,
                                              input logic [IB-1:0] pc);
    return h ^ pc;
  endfunction

  // table port bundles, one slot per table
  logic [IB-1:0] rd_a_idx [NUM_TBL];
  ctr_t          rd_a_val [NUM_TBL];
  logic [IB-1:0] rd_b_idx [NUM_TBL];
  ctr_t          rd_b_val [NUM_TBL];
  logic          wr_en    [NUM_TBL];
  ctr_t          wr_val   [NUM_TBL];

  // lookup side
  ctr_t lk_g_ctr, lk_b_ctr, lk_s_ctr;
  logic lk_use_glb, lk_g_dir, lk_b_dir;

  // commit side
  ctr_t up_g_ctr, up_b_ctr, up_s_ctr;
  logic up_g_dir, up_b_dir, up_disagree;

  always_comb begin
    rd_a_idx[TBL_GLB] = glb_index(lk_hist, lk_pc);
    rd_a_idx[TBL_BIM] = lk_pc;
    rd_a_idx[TBL_SEL] = lk_pc;
    rd_b_idx[TBL_GLB] = glb_index(up_hist, up_pc);
    rd_b_idx[TBL_BIM] = up_pc;
    rd_b_idx[TBL_SEL] = up_pc;
  end

  for (genvar t = 0; t < NUM_TBL; t++) begin : g_tbl
    pred_ctr_table #(.IDX_BITS(IB), .INIT(CTR_WEAK_NT)) u_tbl (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_idx_a (rd_a_idx[t]),
      .rd_val_a (rd_a_val[t]),
      .rd_idx_b (rd_b_idx[t]),
      .rd_val_b (rd_b_val[t]),
      .wr_en    (wr_en[t]),
      .wr_idx   (rd_b_idx[t]),
      .wr_val   (wr_val[t])
    );
  end

  // prediction and agreement confidence
  assign lk_g_ctr   = rd_a_val[TBL_GLB];
  assign lk_b_ctr   = rd_a_val[TBL_BIM];
  assign lk_s_ctr   = rd_a_val[TBL_SEL];
  assign lk_g_dir   = ctr_dir(lk_g_ctr);
  assign lk_b_dir   = ctr_dir(lk_b_ctr);
  assign lk_use_glb = ctr_dir(lk_s_ctr);

  assign lk_taken     = lk_use_glb ? lk_g_dir : lk_b_dir;
  assign lk_confident = ctr_strong(lk_g_ctr) && ctr_strong(lk_b_ctr) &&
                        (lk_g_dir == lk_b_dir);

  // commit-time training
  assign up_g_ctr    = rd_b_val[TBL_GLB];
  assign up_b_ctr    = rd_b_val[TBL_BIM];
  assign up_s_ctr    = rd_b_val[TBL_SEL];
  assign up_g_dir    = ctr_dir(up_g_ctr);
  assign up_b_dir    = ctr_dir(up_b_ctr);
  assign up_disagree = up_g_dir != up_b_dir;

  always_comb begin
    wr_en[TBL_GLB]  = up_valid;
    wr_val[TBL_GLB] = ctr_bump(up_g_ctr, up_taken);
    wr_en[TBL_BIM]  = up_valid;
    wr_val[TBL_BIM] = ctr_bump(up_b_ctr, up_taken);
    wr_en[TBL_SEL]  = up_valid && up_disagree;
    wr_val[TBL_SEL] = ctr_bump(up_s_ctr, up_g_dir == up_taken);
  end

  pred_hist_reg #(.HB(IB)) u_hist (
    .clk        (clk),
    .rst_n      (rst_n),
    .spec_valid (lk_valid),
    .spec_taken (lk_taken),
    .fix_valid  (rp_valid),
    .fix_snap   (rp_hist),
    .fix_taken  (rp_taken),
    .hist       (lk_hist)
  );

  // confident output means both tables agree, so the chosen one does too
  AST_CONF_AGREES: assert property (@(posedge clk) disable iff (!rst_n)
    lk_confident |-> (lk_taken == lk_b_dir) && (lk_taken == lk_g_dir)); // R6

  // a valid lookup records exactly the direction it reported
  AST_SPEC_RECORDS_PRED: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !rp_valid) |=> lk_hist[0] == $past(lk_taken)); // R7

endmodule

// File: tb/tb_combining_predictor.sv
module tb_combining_predictor;

  localparam int IB = 11;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          lk_valid = 1'b0;
  logic [IB+1:2] lk_pc = '0;
  logic          lk_taken, lk_confident;
  logic [IB-1:0] lk_hist;
  logic          up_valid = 1'b0;
  logic [IB+1:2] up_pc = '0;
  logic          up_taken = 1'b0;
  logic [IB-1:0] up_hist = '0;
  logic          rp_valid = 1'b0;
  logic [IB-1:0] rp_hist = '0;
  logic          rp_taken = 1'b0;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  combining_predictor #(.IDX_BITS(IB)) dut (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_pc(lk_pc), .lk_taken(lk_taken),
    .lk_confident(lk_confident), .lk_hist(lk_hist),
    .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken), .up_hist(up_hist),
    .rp_valid(rp_valid), .rp_hist(rp_hist), .rp_taken(rp_taken)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // op: 0 probe (lk_valid low), 1 commit update, 2 repair
  typedef struct packed {
    logic [1:0]    op;
    logic [IB-1:0] pc;
    logic          t;
    logic [IB-1:0] h;
    logic          et;
    logic          ec;
    logic [IB-1:0] eh;
  } vec_t;

  localparam int NV = 31;
  localparam logic [IB-1:0] PA = 11'h040;
  localparam logic [IB-1:0] PB = 11'h080;

  localparam vec_t VEC [NV] = '{
    '{2'd0, PA, 1'b0, 11'd0, 1'b0, 1'b0, 11'd0},  // R1 untrained
    '{2'd1, PA, 1'b1, 11'd0, 1'b0, 1'b0, 11'd0},
    '{2'd0, PA, 1'b0, 11'd0, 1'b1, 1'b0, 11'd0},  // R4 weak taken
    '{2'd1, PA, 1'b1, 11'd0, 1'b0, 1'b0, 11'd0},
    '{2'd0, PA, 1'b0, 11'd0, 1'b1, 1'b1, 11'd0},  // R6 both 3
    '{2'd1, PA, 1'b0, 11'd0, 1'b0, 1'b0, 11'd0},
    '{2'd0, PA, 1'b0, 11'd0, 1'b1, 1'b0, 11'd0},
    '{2'd1, PA, 1'b0, 11'd0, 1'b0, 1'b0, 11'd0},
    '{2'd1, PA, 1'b0, 11'd0, 1'b0, 1'b0, 11'd0},
    '{2'd0, PA, 1'b0, 11'd0, 1'b0, 1'b1, 11'd0},  // R6 both 0
    '{2'd1, PA, 1'b0, 11'd0, 1'b0, 1'b0, 11'd0},
    '{2'd0, PA, 1'b0, 11'd0, 1'b0, 1'b1, 11'd0},  // R4 floor holds
    '{2'd1, PA, 1'b1, 11'd5, 1'b0, 1'b0, 11'd0},
    '{2'd0, PA, 1'b0, 11'd0, 1'b0, 1'b0, 11'd0},  // R5 agree: selector idle
    '{2'd1, PA, 1'b1, 11'd5, 1'b0, 1'b0, 11'd0},
    '{2'd0, PA, 1'b0, 11'd0, 1'b0, 1'b0, 11'd0},  // R3 R5 global chosen
    '{2'd2, 11'd0, 1'b1, 11'd2, 1'b0, 1'b0, 11'd0},
    '{2'd0, PA, 1'b0, 11'd0, 1'b1, 1'b0, 11'd5},  // R2 R8 xor index
    '{2'd1, PA, 1'b0, 11'd5, 1'b0, 1'b0, 11'd0},
    '{2'd0, PA, 1'b0, 11'd0, 1'b1, 1'b0, 11'd5},  // R5 selector kept
    '{2'd1, PA, 1'b0, 11'd5, 1'b0, 1'b0, 11'd0},
    '{2'd0, PA, 1'b0, 11'd0, 1'b0, 1'b0, 11'd5},  // R5 back to bimodal
    '{2'd1, PA, 1'b0, 11'd5, 1'b0, 1'b0, 11'd0},
    '{2'd0, PA, 1'b0, 11'd0, 1'b0, 1'b1, 11'd5},
    '{2'd2, 11'd0, 1'b0, 11'd0, 1'b0, 1'b0, 11'd0},
    '{2'd1, PB, 1'b1, 11'd0, 1'b0, 1'b0, 11'd0},
    '{2'd1, PB, 1'b1, 11'd0, 1'b0, 1'b0, 11'd0},
    '{2'd1, PB, 1'b0, 11'd7, 1'b0, 1'b0, 11'd0},
    '{2'd1, PB, 1'b0, 11'd7, 1'b0, 1'b0, 11'd0},
    '{2'd1, PB, 1'b0, 11'd7, 1'b0, 1'b0, 11'd0},
    '{2'd0, PB, 1'b0, 11'd0, 1'b1, 1'b0, 11'd0}   // R6 strong but opposed
  };

  task automatic idle_inputs();
    lk_valid = 1'b0; up_valid = 1'b0; rp_valid = 1'b0;
  endtask

  initial begin : watchdog
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    #5;
    check("R1 history after reset", lk_hist, 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      idle_inputs();
      case (VEC[i].op)
        2'd0: begin
          lk_pc = VEC[i].pc;
          #5;
          check($sformatf("R3 R6 vec%0d taken", i), lk_taken, VEC[i].et);
          check($sformatf("R6 vec%0d confidence", i), lk_confident, VEC[i].ec);
          check($sformatf("R7 vec%0d history", i), lk_hist, VEC[i].eh);
        end
        2'd1: begin
          up_valid = 1'b1; up_pc = VEC[i].pc;
          up_taken = VEC[i].t; up_hist = VEC[i].h;
        end
        default: begin
          rp_valid = 1'b1; rp_hist = VEC[i].h; rp_taken = VEC[i].t;
        end
      endcase
    end
    @(negedge clk);
    idle_inputs();

    // R7: speculative shift of the predicted direction
    lk_pc = PB; lk_valid = 1'b1;
    #5 check("R7 lookup B predicts taken", lk_taken, 1);
    @(negedge clk);
    lk_pc = PA;
    #5 check("R7 history after taken lookup", lk_hist, 1);
    check("R7 lookup A predicts not-taken", lk_taken, 0);
    @(negedge clk);
    lk_valid = 1'b0;
    #5 check("R7 history after not-taken lookup", lk_hist, 2);

    // R8: repair and speculative shift in one cycle
    @(negedge clk);
    lk_pc = PB; lk_valid = 1'b1;
    rp_valid = 1'b1; rp_hist = 11'd3; rp_taken = 1'b0;
    @(negedge clk);
    idle_inputs();
    #5 check("R8 repair wins over shift", lk_hist, 6);

    // R7: invalid lookups leave the history alone
    @(negedge clk);
    #5 check("R7 history held with lk_valid low", lk_hist, 6);

    // R8: repair uses snapshot bits below the top, top bit dropped
    @(negedge clk);
    rp_valid = 1'b1; rp_hist = 11'h7FF; rp_taken = 1'b0;
    @(negedge clk);
    rp_valid = 1'b1; rp_hist = 11'd0; rp_taken = 1'b0;
    #5 check("R8 repair wrap", lk_hist, 11'h7FE);
    @(negedge clk);
    idle_inputs();
    #5 check("R8 repair to zero", lk_hist, 0);

    // R9: commit update and lookup of the same entry in one cycle
    @(negedge clk);
    lk_pc = 11'h0C0;
    up_valid = 1'b1; up_pc = 11'h0C0; up_taken = 1'b1; up_hist = 11'd0;
    #5 check("R9 lookup sees old counter", lk_taken, 0);
    @(negedge clk);
    idle_inputs();
    #5 check("R9 lookup sees update next cycle", lk_taken, 1);
    check("R9 confidence still low", lk_confident, 0);

    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule